// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a small data cache placed between a processor's operand port and an external memory bus. It holds 64 words of 32 bits, arranged as 16 direct-mapped lines of four words. Each line keeps one key, made of the upper address bits and the 3-bit address-space code, and one valid flag per word. A read that finds its word valid under a matching key is answered in the same cycle without touching the bus. Every other access is passed to the external port as a single 32-bit transfer.

Writes always go to the external memory, and a write that hits also updates the cached word. A run-time control input decides whether a full-word write that misses claims a cache entry. A synchronous flush input drops all cached contents, and a cache-enable input of 0 sends every access to the bus and leaves the cache unchanged. The requester and the memory each see a req/ack pair. The requester holds its request and its fields until it sees an ack.

Top module: `wt_dcache`

## Requirements
- R1: The line index is address bits [7:4] and the word-in-line select is bits [3:2]. Two addresses that differ only in bits [31:8] share a line, so filling one evicts the other.
- R2: The 3-bit space code is part of the line key. The same address under a different space code misses and is fetched from memory under that code.
- R3: A read whose key matches and whose word is valid is acked in the cycle it is presented, with the cached data and without raising mem_req.
- R4: A read miss raises mem_req with mem_we=0 and all four byte strobes set, holding the request until mem_ack. It returns mem_rdata with cpu_ack in the mem_ack cycle, and the word then hits.
- R5: Each word has its own valid flag. A fill makes only its own word valid. A fill under a different key first clears the other three words of the line.
- R6: A write hit goes to memory with the given byte strobes and updates only the strobed bytes of the cached word. Strobe bit k covers data bits [8k+7:8k].
- R7: A write miss allocates the word with the written data only when wr_alloc=1 and all four strobes are set. Otherwise the cache is unchanged.
- R8: Every write raises mem_req with mem_we=1 and is acked only in the cycle mem_ack is high.
- R9: A one-cycle flush pulse invalidates every word. When the flush falls in the same cycle as a fill completing, the flush wins and the filled word is not valid afterwards.
- R10: While cache_en=0 every access goes to memory, and no fill, allocation or write-hit update takes place.
- R11: After reset every word is invalid, and cpu_ack and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | 1 enables lookup and allocation |
| wr_alloc | input | 1 | 1 lets a full-word write miss allocate |
| flush | input | 1 | Invalidate all words this cycle |
| cpu_req | input | 1 | Requester access pending |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 32 | Byte address |
| cpu_space | input | 3 | Address-space code |
| cpu_be | input | 4 | Byte strobes for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Access complete |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| mem_req | output | 1 | External transfer pending |
| mem_we | output | 1 | External write |
| mem_addr | output | 32 | External byte address |
| mem_space | output | 3 | External address-space code |
| mem_be | output | 4 | External byte strobes |
| mem_wdata | output | 32 | External write data |
| mem_ack | input | 1 | External transfer complete |
| mem_rdata | input | 32 | External read data |

## Verification
The flush and the completion of a fill can occur in the same clock edge. Then one path clears every valid flag while the other sets one. The bench provokes this by raising flush in exactly the cycle it sees mem_ack high for a read miss, and also at random points of a long random run. It judges the outcome by re-reading the same address, which must go to the bus again.

// File: rtl/dc_pkg.sv
package dc_pkg;

   // controller phase: idle/lookup or waiting on the external port
   typedef enum logic [1:0] {
      DC_IDLE = 2'd0,
      DC_BUS  = 2'd1
   } dc_state_e;

   // what the completing transfer does to the arrays
   typedef enum logic [1:0] {
      UPD_NONE  = 2'd0,
      UPD_FILL  = 2'd1,
      UPD_MERGE = 2'd2
   } dc_upd_e;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int LINES = 16,
   parameter int WORDS = 4,
   parameter int KEY_W = 27,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [WSEL_W-1:0] lk_word,
   input  logic [KEY_W-1:0]  lk_key,
   output logic              lk_hit,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [KEY_W-1:0]  wr_key
);

   logic [KEY_W-1:0] key_q [LINES];
   logic [WORDS-1:0] vld_q [LINES];
   logic [WORDS-1:0] wr_onehot;

   assign wr_onehot = WORDS'(1) << wr_word;
   assign lk_hit    = (key_q[lk_idx] == lk_key) && vld_q[lk_idx][lk_word];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) begin
            key_q[l] <= '0;
            vld_q[l] <= '0;
         end
      end else if (flush) begin
         for (int l = 0; l < LINES; l++) vld_q[l] <= '0;
      end else if (wr_en) begin
         if (key_q[wr_idx] != wr_key) begin
            key_q[wr_idx] <= wr_key;
            vld_q[wr_idx] <= wr_onehot;
         end else begin
            vld_q[wr_idx] <= vld_q[wr_idx] | wr_onehot;
         end
      end
   end

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [LANES-1:0]  wr_be,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] merged;

   assign rd_data = mem_q[rd_addr];

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : mem_q[wr_addr][b*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= merged;
   end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
   import dc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int SPACE_W = 3,
   localparam int LANES  = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cache_en,
   input  logic               wr_alloc,
   input  logic               flush,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [SPACE_W-1:0] cpu_space,
   input  logic [LANES-1:0]   cpu_be,
   input  logic [DATA_W-1:0]  cpu_wdata,
   input  logic               look_hit,
   input  logic               mem_ack,
   output logic               busy,
   output logic               cpu_ack,
   output dc_upd_e            upd,
   output logic [ADDR_W-1:0]  cap_addr,
   output logic [SPACE_W-1:0] cap_space,
   output logic               cap_we,
   output logic [LANES-1:0]   cap_be,
   output logic [DATA_W-1:0]  cap_wdata
);

   dc_state_e state_q;
   logic      cap_en;
   logic      cap_alloc;
   logic      rd_hit_now;
   logic      start_bus;
   logic      done;

   assign busy       = (state_q == DC_BUS);
   assign rd_hit_now = !busy && cpu_req && !cpu_we && cache_en && look_hit;
   assign start_bus  = !busy && cpu_req && !rd_hit_now;
   assign done       = busy && mem_ack;
   assign cpu_ack    = rd_hit_now || done;

   always_comb begin
      upd = UPD_NONE;
      if (done && !flush && cap_en) begin
         if (!cap_we)                    upd = UPD_FILL;
         else if (look_hit)              upd = UPD_MERGE;
         else if (cap_alloc && &cap_be)  upd = UPD_FILL;
         else                            upd = UPD_NONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= DC_IDLE;
         cap_addr  <= '0;
         cap_space <= '0;
         cap_we    <= 1'b0;
         cap_be    <= '0;
         cap_wdata <= '0;
         cap_en    <= 1'b0;
         cap_alloc <= 1'b0;
      end else begin
         case (state_q)
            DC_IDLE: begin
               if (start_bus) begin
                  state_q   <= DC_BUS;
                  cap_addr  <= cpu_addr;
                  cap_space <= cpu_space;
                  cap_we    <= cpu_we;
                  cap_be    <= cpu_be;
                  cap_wdata <= cpu_wdata;
                  cap_en    <= cache_en;
                  cap_alloc <= wr_alloc;
               end
            end
            DC_BUS: begin
               if (mem_ack) state_q <= DC_IDLE;
            end
            default: state_q <= DC_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
   import dc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int SPACE_W = 3,
   parameter int LINES   = 16,
   parameter int WORDS   = 4,
   localparam int LANES  = DATA_W / 8,
   localparam int BOFF_W = $clog2(LANES),
   localparam int WSEL_W = $clog2(WORDS),
   localparam int IDX_W  = $clog2(LINES),
   localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BOFF_W,
   localparam int KEY_W  = TAG_W + SPACE_W,
   localparam int DEPTH  = LINES * WORDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cache_en,
   input  logic               wr_alloc,
   input  logic               flush,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [SPACE_W-1:0] cpu_space,
   input  logic [LANES-1:0]   cpu_be,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic               cpu_ack,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [SPACE_W-1:0] mem_space,
   output logic [LANES-1:0]   mem_be,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic               mem_ack,
   input  logic [DATA_W-1:0]  mem_rdata
);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || LANES < 1) begin : g_bad_data_w
      $error("wt_dcache: DATA_W must be a multiple of 8");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("wt_dcache: LINES must be a power of two, at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("wt_dcache: WORDS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wt_dcache: address too narrow for the chosen geometry");
   end

   logic               busy;
   dc_upd_e            upd;
   logic [ADDR_W-1:0]  cap_addr;
   logic [SPACE_W-1:0] cap_space;
   logic               cap_we;
   logic [LANES-1:0]   cap_be;
   logic [DATA_W-1:0]  cap_wdata;
   logic               look_hit;

   logic [ADDR_W-1:0]  lk_addr;
   logic [SPACE_W-1:0] lk_space;
   logic [IDX_W-1:0]   lk_idx;
   logic [WSEL_W-1:0]  lk_word;
   logic [KEY_W-1:0]   lk_key;
   logic [IDX_W-1:0]   cap_idx;
   logic [WSEL_W-1:0]  cap_word;
   logic [KEY_W-1:0]   cap_key;
   logic [DATA_W-1:0]  rd_word;
   logic               unused_lsb;

   // one lookup port: the live request when idle, the held one while on the bus
   assign lk_addr  = busy ? cap_addr  : cpu_addr;
   assign lk_space = busy ? cap_space : cpu_space;
   assign lk_idx   = lk_addr[BOFF_W + WSEL_W +: IDX_W];
   assign lk_word  = lk_addr[BOFF_W +: WSEL_W];
   assign lk_key   = {lk_addr[ADDR_W-1 -: TAG_W], lk_space};
   assign unused_lsb = ^lk_addr[BOFF_W-1:0];

   assign cap_idx  = cap_addr[BOFF_W + WSEL_W +: IDX_W];
   assign cap_word = cap_addr[BOFF_W +: WSEL_W];
   assign cap_key  = {cap_addr[ADDR_W-1 -: TAG_W], cap_space};

   dc_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SPACE_W(SPACE_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cache_en (cache_en),
      .wr_alloc (wr_alloc),
      .flush    (flush),
      .cpu_req  (cpu_req),
      .cpu_we   (cpu_we),
      .cpu_addr (cpu_addr),
      .cpu_space(cpu_space),
      .cpu_be   (cpu_be),
      .cpu_wdata(cpu_wdata),
      .look_hit (look_hit),
      .mem_ack  (mem_ack),
      .busy     (busy),
      .cpu_ack  (cpu_ack),
      .upd      (upd),
      .cap_addr (cap_addr),
      .cap_space(cap_space),
      .cap_we   (cap_we),
      .cap_be   (cap_be),
      .cap_wdata(cap_wdata)
   );

   dc_tag_store #(
      .LINES(LINES),
      .WORDS(WORDS),
      .KEY_W(KEY_W)
   ) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .lk_idx (lk_idx),
      .lk_word(lk_word),
      .lk_key (lk_key),
      .lk_hit (look_hit),
      .wr_en  (upd == UPD_FILL),
      .wr_idx (cap_idx),
      .wr_word(cap_word),
      .wr_key (cap_key)
   );

   dc_data_store #(
      .DEPTH (DEPTH),
      .DATA_W(DATA_W)
   ) u_data (
      .clk    (clk),
      .rd_addr({lk_idx, lk_word}),
      .rd_data(rd_word),
      .wr_en  (upd != UPD_NONE),
      .wr_addr({cap_idx, cap_word}),
      .wr_be  ((upd == UPD_FILL) ? {LANES{1'b1}} : cap_be),
      .wr_data(cap_we ? cap_wdata : mem_rdata)
   );

   assign cpu_rdata = busy ? mem_rdata : rd_word;
   assign mem_req   = busy;
   assign mem_we    = cap_we;
   assign mem_addr  = cap_addr;
   assign mem_space = cap_space;
   assign mem_be    = cap_we ? cap_be : {LANES{1'b1}};
   assign mem_wdata = cap_wdata;

endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cache_en,
   input logic              flush,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_ack,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [LANES-1:0]  mem_be,
   input logic [ADDR_W-1:0] mem_addr
);

   // an ack without a bus transfer is only ever a read hit with the cache on
   assert_hit_is_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !mem_req) |-> (!cpu_we && cache_en && cpu_req));

   // external reads always carry every byte strobe
   assert_read_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_be == {LANES{1'b1}}));

   // a pending transfer stays up with a steady address until acked
   assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // writes complete only through the external port
   assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_we) |-> (mem_req && mem_we && mem_ack));

   // the cycle after a flush nothing can hit
   assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !(cpu_ack && !mem_req));

   // disabled cache never answers locally
   assert_off_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cache_en && cpu_req) |-> !(cpu_ack && !mem_req));

   // no bus transfer survives the cycle after reset release
   assert_idle_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!mem_req && !cpu_ack));

endmodule

bind wt_dcache dc_checker #(
   .ADDR_W(ADDR_W),
   .LANES (LANES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cache_en(cache_en),
   .flush   (flush),
   .cpu_req (cpu_req),
   .cpu_we  (cpu_we),
   .cpu_ack (cpu_ack),
   .mem_req (mem_req),
   .mem_we  (mem_we),
   .mem_ack (mem_ack),
   .mem_be  (mem_be),
   .mem_addr(mem_addr)
);

// File: tb/sim_wt_dcache.sv
module sim_wt_dcache;

   localparam int PERIOD = 20;  // 50 MHz

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cache_en, wr_alloc, flush;
   logic        cpu_req, cpu_we;
   logic [31:0] cpu_addr;
   logic [2:0]  cpu_space;
   logic [3:0]  cpu_be;
   logic [31:0] cpu_wdata;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [2:0]  mem_space;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_ack;
   logic [31:0] mem_rdata;

   always #(PERIOD/2) clk = ~clk;

   wt_dcache u0 (
      .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .wr_alloc(wr_alloc), .flush(flush),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_space(cpu_space),
      .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_space(mem_space),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int errors = 0;

   // bench reference of cache contents and memory
   logic [26:0] r_key [16];
   logic [3:0]  r_val [16];
   logic [31:0] r_dat [64];
   bit          r_en, r_alloc;
   logic [31:0] gmem [logic [32:0]];
   logic [31:0] xmem [logic [32:0]];

   function automatic logic [31:0] pat(input logic [2:0] sp, input logic [31:0] a);
      return {sp, a[30:2]} ^ 32'hC3A5_0F1E;
   endfunction

   function automatic logic [31:0] gread(input logic [2:0] sp, input logic [31:0] a);
      logic [32:0] k;
      k = {sp, a[31:2]};
      return gmem.exists(k) ? gmem[k] : pat(sp, a);
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
      return r;
   endfunction

   function automatic void ref_fill(input logic [3:0] idx, input logic [1:0] w,
                                    input logic [26:0] key, input logic [31:0] d);
      if (r_key[idx] != key) begin
         r_key[idx] = key;
         r_val[idx] = 4'b0001 << w;
      end else begin
         r_val[idx] = r_val[idx] | (4'b0001 << w);
      end
      r_dat[{idx, w}] = d;
   endfunction

   function automatic logic [31:0] mk(input int t, input int idx, input int w);
      logic [23:0] tg;
      case (t)
         0:       tg = 24'h000123;
         1:       tg = 24'h00BEEF;
         default: tg = 24'h0F0F00;
      endcase
      return {tg, idx[3:0], w[1:0], 2'b00};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // external memory model: 0..2 wait cycles, acks for one cycle
   initial begin
      int lat;
      lat = 0;
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(posedge clk);
         if (mem_ack) begin
            mem_ack <= 1'b0;
         end else if (mem_req) begin
            if (lat == 0) begin
               logic [32:0] k;
               logic [31:0] old;
               k = {mem_space, mem_addr[31:2]};
               old = xmem.exists(k) ? xmem[k] : pat(mem_space, mem_addr);
               if (mem_we) xmem[k] = merge(old, mem_wdata, mem_be);
               else mem_rdata <= old;
               mem_ack <= 1'b1;
               lat = $urandom_range(0, 2);
            end else begin
               lat--;
            end
         end
      end
   end

   task automatic access(input bit we, input logic [31:0] a, input logic [2:0] sp,
                         input logic [3:0] be, input logic [31:0] wd,
                         input bit fl_ack, input string req);
      logic [3:0]  idx;
      logic [1:0]  w;
      logic [26:0] key;
      bit          hit, exp_bus, bus, fl;
      logic [31:0] exp_rd, rd;
      int          cyc;
      idx = a[7:4];
      w   = a[3:2];
      key = {a[31:8], sp};
      hit = r_en && (r_key[idx] == key) && r_val[idx][w];
      exp_bus = we || !hit;
      exp_rd  = hit ? r_dat[{idx, w}] : gread(sp, a);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_space = sp;
      cpu_be = be; cpu_wdata = wd;
      bus = 0; fl = 0; cyc = 0; rd = '0;
      while (1) begin
         #1;
         if (mem_req) bus = 1;
         if (cpu_ack) begin
            rd = cpu_rdata;
            if (fl_ack && mem_ack) begin
               flush = 1'b1;
               fl = 1;
            end
            break;
         end
         @(negedge clk);
         cyc++;
      end
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
      flush = 1'b0;
      chk(bus == exp_bus, req, we ? "write bus use" : "read bus use", 32'(bus), 32'(exp_bus));
      if (!we) chk(rd == exp_rd, req, "read data", rd, exp_rd);
      if (!exp_bus) chk(cyc == 0, req, "hit latency", cyc, 0);
      // reference update
      if (we) gmem[{sp, a[31:2]}] = merge(gread(sp, a), wd, be);
      if (fl) begin
         for (int l = 0; l < 16; l++) r_val[l] = 4'b0000;
      end else if (r_en) begin
         if (!we) begin
            if (!hit) ref_fill(idx, w, key, exp_rd);
         end else if (hit) begin
            r_dat[{idx, w}] = merge(r_dat[{idx, w}], wd, be);
         end else if (r_alloc && be == 4'hF) begin
            ref_fill(idx, w, key, wd);
         end
      end
   endtask

   task automatic rd(input logic [31:0] a, input logic [2:0] sp, input string req);
      access(1'b0, a, sp, 4'hF, 32'h0, 1'b0, req);
   endtask

   task automatic wr(input logic [31:0] a, input logic [2:0] sp, input logic [3:0] be,
                     input logic [31:0] d, input string req);
      access(1'b1, a, sp, be, d, 1'b0, req);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk);
      #1;
      flush = 1'b0;
      for (int l = 0; l < 16; l++) r_val[l] = 4'b0000;
   endtask

   task automatic set_ctrl(input bit en, input bit al);
      @(negedge clk);
      cache_en = en; wr_alloc = al;
      r_en = en; r_alloc = al;
   endtask

   initial begin
      #(PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      for (int l = 0; l < 16; l++) begin r_key[l] = '0; r_val[l] = '0; end
      for (int i = 0; i < 64; i++) r_dat[i] = '0;
      rst_n = 1'b0; cache_en = 1'b1; wr_alloc = 1'b1; flush = 1'b0;
      r_en = 1; r_alloc = 1;
      cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_space = '0; cpu_be = '0; cpu_wdata = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!cpu_ack && !mem_req, "R11", "idle after reset", {cpu_ack, mem_req}, 0);

      // R11 / R4 / R3: first read misses, second hits
      rd(mk(0, 3, 0), 3'd1, "R11");
      rd(mk(0, 3, 0), 3'd1, "R3");
      // R5: neighbouring word in the same line is not valid yet
      rd(mk(0, 3, 1), 3'd1, "R5");
      rd(mk(0, 3, 1), 3'd1, "R3");
      // R1 / R5: different tag on same line replaces and clears siblings
      rd(mk(1, 3, 2), 3'd1, "R1");
      rd(mk(1, 3, 0), 3'd1, "R5");
      rd(mk(0, 3, 0), 3'd1, "R1");
      // R2: same address, other space code
      rd(mk(2, 9, 1), 3'd1, "R2");
      rd(mk(2, 9, 1), 3'd5, "R2");
      rd(mk(2, 9, 1), 3'd5, "R2");
      // R6: partial write hit, then read merged word locally
      wr(mk(2, 9, 1), 3'd5, 4'b0011, 32'hDEAD_BEEF, "R6");
      rd(mk(2, 9, 1), 3'd5, "R6");
      // R7: allocation rules
      wr(mk(0, 12, 2), 3'd2, 4'hF, 32'h1234_5678, "R7");
      rd(mk(0, 12, 2), 3'd2, "R7");
      wr(mk(0, 13, 2), 3'd2, 4'b1000, 32'hAAAA_5555, "R7");
      rd(mk(0, 13, 2), 3'd2, "R7");
      set_ctrl(1, 0);
      wr(mk(0, 14, 0), 3'd2, 4'hF, 32'h0BAD_F00D, "R7");
      rd(mk(0, 14, 0), 3'd2, "R7");
      wr(mk(0, 14, 0), 3'd2, 4'hF, 32'h5EED_0001, "R8");
      set_ctrl(1, 1);
      // R10: disabled cache goes to memory and does not update
      set_ctrl(0, 1);
      rd(mk(0, 12, 2), 3'd2, "R10");
      wr(mk(0, 12, 2), 3'd2, 4'hF, 32'hFEED_FACE, "R10");
      rd(mk(0, 7, 3), 3'd2, "R10");
      set_ctrl(1, 1);
      rd(mk(0, 12, 2), 3'd2, "R10");
      rd(mk(0, 7, 3), 3'd2, "R10");
      // R9: flush drops everything
      rd(mk(1, 4, 0), 3'd3, "R9");
      do_flush();
      rd(mk(1, 4, 0), 3'd3, "R9");
      rd(mk(1, 4, 0), 3'd3, "R9");
      // R9: flush in the same cycle a fill completes
      rd(mk(1, 5, 1), 3'd3, "R9");
      do_flush();
      access(1'b0, mk(1, 5, 1), 3'd3, 4'hF, 32'h0, 1'b1, "R9");
      rd(mk(1, 5, 1), 3'd3, "R9");

      // random mix
      for (int i = 0; i < 1500; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 2) begin
            do_flush();
         end else if (r < 5) begin
            set_ctrl($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1);
         end else begin
            bit          we;
            logic [3:0]  be;
            logic [2:0]  sp;
            logic [31:0] a;
            we = ($urandom_range(0, 2) == 0);
            be = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'hF;
            sp = ($urandom_range(0, 1) == 0) ? 3'd1 : 3'd6;
            a  = mk($urandom_range(0, 2), $urandom_range(0, 15), $urandom_range(0, 3));
            access(we, a, sp, be, $urandom, $urandom_range(0, 19) == 0,
                   we ? "R8" : "R4");
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule